// File: doc/BRIEF.md
# Addressed Serial Control and Status Port

This block is the host-facing control port of a digital audio receiver. A host drives four wires: a chip enable, a serial clock, a data line into the block and a data line out of it. Each transfer opens with an 8-bit address that picks one of two registers. The write register holds the configuration: the source of the demodulator input, the sources of two pass-through outputs, and the audio output format. The read register reports what the receiver core has decoded: a sample-rate code, the copy-permit flag, the first channel-status bit and an 8-bit category code.

All four host wires are resynchronised into the system clock domain and edge-detected there, so the port has a single clock. The block also contains the three source selectors. Each one routes one of six serial input lines, or a constant low, to its output. The status register loads on a valid strobe from the core. A lock-lost strobe forces it into a cleared state that carries its own sample-rate code. A read takes a snapshot of the status register at the end of the address phase, so the word shifted out is consistent even if the core updates the register during the readout.

Top module: `serial_ctl_port`

## Requirements
- R1: Address bits are indexed by arrival order, bit 0 first. The write address is 1,0,1,0,0,1,1,0 and the read address is 0,1,1,0,0,1,1,0 in that order. A transfer with any other address changes no configuration output, keeps `sdo` low and never raises `read_pending`.
- R2: Data bit k of a write is the (k+1)-th bit after the address. Bits 5..7 form `demod_sel`, bits 8..10 form `thru1_sel` and bits 11..13 form `thru2_sel`, each with its lowest-numbered bit as the LSB. Bit 14 drives `fmt_lsb20` (0 = 16-bit MSB-first, 1 = 20-bit LSB-first). Bits 0..4 and bit 15 have no effect.
- R3: A write takes effect only when chip enable falls after at least 24 serial clock rising edges. A shorter write leaves the configuration unchanged. Bits after the 24th are ignored.
- R4: After reset every configuration output is 0, and the configuration changes at no time other than a write commit.
- R5: For each selector, a code c from 0 to 5 routes `din[c]` to its output and codes 6 and 7 drive it low. The path is combinational.
- R6: The read word bit Dk leaves on `sdo` in order D0 first. D0 and D13..D15 are 0, D1 = `st_rate[0]`, D2 = `st_rate[1]`, D3 = copy permit (1 = copying allowed), D4 = the first channel-status bit, and D5..D12 = `st_category[0]`..`st_category[7]`.
- R7: The rate code (D1,D2) is (1,1) for 32 kHz, (0,0) for 44.1 kHz and (0,1) for 48 kHz. (1,0) marks data cleared by a lock error.
- R8: After reset, and after any `lock_lost` pulse, the read word is 0x0002 (only D1 set). `lock_lost` wins over `st_valid` in the same cycle.
- R9: An `st_valid` pulse without `lock_lost` loads the status fields into the read register.
- R10: On a read, the falling serial clock edges that follow the address present D0, D1, ... D15 on `sdo`, and then 0. The word is the register content at the 8th rising edge, unaffected by later status changes. `sdo` is low whenever no read is active.
- R11: `read_pending` rises when a read address completes and falls when chip enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sce | input | 1 | Host chip enable, high during a transfer |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Host serial data into the block |
| sdo | output | 1 | Serial data to the host |
| din | input | N_SRC | Candidate serial input lines |
| demod_in | output | 1 | Selected demodulator input |
| thru1_out | output | 1 | First pass-through output |
| thru2_out | output | 1 | Second pass-through output |
| st_rate | input | 2 | Rate code from the core, bit 0 = D1, bit 1 = D2 |
| st_copy_ok | input | 1 | Copy permit from the core |
| st_cs0 | input | 1 | First channel-status bit |
| st_category | input | 8 | Category code |
| st_valid | input | 1 | Load strobe for the status fields |
| lock_lost | input | 1 | Lock-loss strobe |
| demod_sel | output | 3 | Demodulator source code |
| thru1_sel | output | 3 | First pass-through source code |
| thru2_sel | output | 3 | Second pass-through source code |
| fmt_lsb20 | output | 1 | Audio format select |
| read_pending | output | 1 | A read transfer is in progress |

## Verification
Each host wire passes two synchroniser flops and one edge register. A configuration change therefore appears three clock edges after chip enable falls, and a new `sdo` bit three edges after a serial clock fall. A status strobe reaches the register one edge later. The bench holds each serial clock level for six system clocks and samples `sdo` just before it raises the serial clock, so every bit has settled. It waits at least ten clocks after chip enable drops before it compares the configuration, and it reads the selector outputs one time step after it changes `din`.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int SEL_W      = 3;
  localparam int CAT_W      = 8;
  // Address vectors are indexed by arrival order (bit 0 arrives first)
  localparam logic [ADDR_W-1:0] WR_ADDR = 8'h65;
  localparam logic [ADDR_W-1:0] RD_ADDR = 8'h66;
  // Only data bits CFG_LO..CFG_HI of a write carry configuration
  localparam int CFG_LO = 5;
  localparam int CFG_HI = 14;
  localparam int CFG_W  = CFG_HI - CFG_LO + 1;
  localparam logic [DATA_W-1:0] STAT_CLEARED = 16'h0002;

  typedef struct packed {
    logic             fmt_lsb20;
    logic [SEL_W-1:0] thru2;
    logic [SEL_W-1:0] thru1;
    logic [SEL_W-1:0] demod;
  } cfg_t;

  function automatic logic [DATA_W-1:0] stat_pack(
    input logic [1:0] rate, input logic copy_ok,
    input logic cs0, input logic [CAT_W-1:0] cat);
    logic [DATA_W-1:0] w;
    w = '0;
    w[2:1]  = rate;
    w[3]    = copy_ok;
    w[4]    = cs0;
    w[12:5] = cat;
    return w;
  endfunction
endpackage

// File: rtl/scp_front.sv
module scp_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sce,
  input  logic sclk,
  input  logic sdi,
  output logic ce_s,
  output logic ce_fall,
  output logic cl_rise,
  output logic cl_fall,
  output logic di_s
);
  // bit 2 = chip enable, bit 1 = serial clock, bit 0 = data
  logic [SYNC_STAGES-1:0][2:0] sync_q;
  logic ce_d, cl_d, cl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      ce_d   <= 1'b0;
      cl_d   <= 1'b0;
    end else begin
      sync_q[0] <= {sce, sclk, sdi};
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      ce_d <= ce_s;
      cl_d <= cl_s;
    end
  end

  assign ce_s    = sync_q[SYNC_STAGES-1][2];
  assign cl_s    = sync_q[SYNC_STAGES-1][1];
  assign di_s    = sync_q[SYNC_STAGES-1][0];
  assign cl_rise = cl_s & ~cl_d;
  assign cl_fall = ~cl_s & cl_d;
  assign ce_fall = ce_d & ~ce_s;
endmodule

// File: rtl/scp_status.sv
module scp_status
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        st_rate,
  input  logic              st_copy_ok,
  input  logic              st_cs0,
  input  logic [CAT_W-1:0]  st_category,
  input  logic              st_valid,
  input  logic              lock_lost,
  output logic [DATA_W-1:0] stat_word
);
  always_ff @(posedge clk) begin
    if (!rst_n)         stat_word <= STAT_CLEARED;
    else if (lock_lost) stat_word <= STAT_CLEARED;
    else if (st_valid)  stat_word <= stat_pack(st_rate, st_copy_ok, st_cs0, st_category);
  end

  // R8
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> (stat_word == STAT_CLEARED));
  // R9
  stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !lock_lost) |=> (stat_word[12:5] == $past(st_category)
                                  && stat_word[2:1] == $past(st_rate)));
endmodule

// File: rtl/scp_shift.sv
module scp_shift
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              ce_fall,
  input  logic              cl_rise,
  input  logic              cl_fall,
  input  logic              di_s,
  input  logic [DATA_W-1:0] stat_word,
  output logic              sdo_q,
  output logic              rd_act,
  output logic              commit,
  output logic [CFG_W-1:0]  cfg_bits
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int IDX_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] snap_q;
  logic [IDX_W-1:0]  rd_idx;

  // named events
  logic addr_done, rd_hit, wr_hit, frame_full, next_bit;
  assign addr_done  = ce_s & cl_rise & (bit_cnt == CNT_W'(ADDR_W - 1));
  assign rd_hit     = ({di_s, addr_q[ADDR_W-2:0]} == RD_ADDR);
  assign wr_hit     = (addr_q == WR_ADDR);
  assign frame_full = (bit_cnt == CNT_W'(FRAME_BITS));
  assign commit     = ce_fall & frame_full & wr_hit;

  always_comb begin
    next_bit = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      if (rd_idx == IDX_W'(k)) next_bit = snap_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      addr_q   <= '0;
      cfg_bits <= '0;
      snap_q   <= '0;
      rd_idx   <= '0;
      rd_act   <= 1'b0;
      sdo_q    <= 1'b0;
    end else if (!ce_s) begin
      bit_cnt <= '0;
      addr_q  <= '0;
      rd_idx  <= '0;
      rd_act  <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      if (cl_rise) begin
        for (int k = 0; k < ADDR_W; k++)
          if (bit_cnt == CNT_W'(k)) addr_q[k] <= di_s;
        for (int k = 0; k < CFG_W; k++)
          if (bit_cnt == CNT_W'(ADDR_W + CFG_LO + k)) cfg_bits[k] <= di_s;
        if (!frame_full) bit_cnt <= bit_cnt + CNT_W'(1);
        if (addr_done && rd_hit) begin
          rd_act <= 1'b1;
          snap_q <= stat_word;
        end
      end
      if (cl_fall && rd_act) begin
        sdo_q <= next_bit;
        if (rd_idx != IDX_W'(DATA_W)) rd_idx <= rd_idx + IDX_W'(1);
      end
    end
  end

  // R10
  snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && $past(rd_act)) |-> $stable(snap_q));
  // R10
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |-> !sdo_q);
  // R11
  rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act) |-> $past(addr_done && rd_hit));
  // R11
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> !rd_act);
endmodule

// File: rtl/scp_mux.sv
module scp_mux #(
  parameter int N_SRC = 6,
  parameter int SEL_W = 3,
  parameter int N_OUT = 3
) (
  input  logic [N_SRC-1:0]            din,
  input  logic [N_OUT-1:0][SEL_W-1:0] sel,
  output logic [N_OUT-1:0]            dout
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_path
    always_comb begin
      dout[g] = 1'b0;
      for (int k = 0; k < N_SRC; k++)
        if (sel[g] == SEL_W'(k)) dout[g] = din[k];
      // R5
      if (!$isunknown(sel[g]) && sel[g] >= SEL_W'(N_SRC))
        sel_gnd_chk: assert (dout[g] == 1'b0);
    end
  end
endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
  import scp_pkg::*;
#(
  parameter int N_SRC       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sce,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  input  logic [N_SRC-1:0] din,
  output logic             demod_in,
  output logic             thru1_out,
  output logic             thru2_out,
  input  logic [1:0]       st_rate,
  input  logic             st_copy_ok,
  input  logic             st_cs0,
  input  logic [CAT_W-1:0] st_category,
  input  logic             st_valid,
  input  logic             lock_lost,
  output logic [SEL_W-1:0] demod_sel,
  output logic [SEL_W-1:0] thru1_sel,
  output logic [SEL_W-1:0] thru2_sel,
  output logic             fmt_lsb20,
  output logic             read_pending
);
  logic ce_s, ce_fall, cl_rise, cl_fall, di_s, commit;
  logic [CFG_W-1:0]  cfg_bits;
  logic [DATA_W-1:0] stat_word;
  cfg_t              cfg_q;
  logic [2:0][SEL_W-1:0] sels;
  logic [2:0]            routed;

  scp_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sce(sce), .sclk(sclk), .sdi(sdi),
    .ce_s(ce_s), .ce_fall(ce_fall), .cl_rise(cl_rise), .cl_fall(cl_fall), .di_s(di_s));

  scp_status u_status (
    .clk(clk), .rst_n(rst_n), .st_rate(st_rate), .st_copy_ok(st_copy_ok),
    .st_cs0(st_cs0), .st_category(st_category), .st_valid(st_valid),
    .lock_lost(lock_lost), .stat_word(stat_word));

  scp_shift u_shift (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .ce_fall(ce_fall), .cl_rise(cl_rise),
    .cl_fall(cl_fall), .di_s(di_s), .stat_word(stat_word), .sdo_q(sdo),
    .rd_act(read_pending), .commit(commit), .cfg_bits(cfg_bits));

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (commit) cfg_q <= cfg_t'(cfg_bits);
  end

  assign sels[0] = cfg_q.demod;
  assign sels[1] = cfg_q.thru1;
  assign sels[2] = cfg_q.thru2;

  scp_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W), .N_OUT(3)) u_mux (
    .din(din), .sel(sels), .dout(routed));

  assign demod_in  = routed[0];
  assign thru1_out = routed[1];
  assign thru2_out = routed[2];
  assign demod_sel = cfg_q.demod;
  assign thru1_sel = cfg_q.thru1;
  assign thru2_sel = cfg_q.thru2;
  assign fmt_lsb20 = cfg_q.fmt_lsb20;

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_q));
endmodule

// File: tb/serial_ctl_port_bench.sv
module serial_ctl_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sce = 0, sclk = 0, sdi = 0;
  logic sdo;
  logic [5:0] din = '0;
  logic demod_in, thru1_out, thru2_out;
  logic [1:0] st_rate = '0;
  logic st_copy_ok = 0, st_cs0 = 0, st_valid = 0, lock_lost = 0;
  logic [7:0] st_category = '0;
  logic [2:0] demod_sel, thru1_sel, thru2_sel;
  logic fmt_lsb20, read_pending;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctl_port u_serial_ctl_port (
    .clk(clk), .rst_n(rst_n), .sce(sce), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .din(din), .demod_in(demod_in), .thru1_out(thru1_out), .thru2_out(thru2_out),
    .st_rate(st_rate), .st_copy_ok(st_copy_ok), .st_cs0(st_cs0),
    .st_category(st_category), .st_valid(st_valid), .lock_lost(lock_lost),
    .demod_sel(demod_sel), .thru1_sel(thru1_sel), .thru2_sel(thru2_sel),
    .fmt_lsb20(fmt_lsb20), .read_pending(read_pending));

  localparam logic [7:0] A_WR = {1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1};
  localparam logic [7:0] A_RD = {1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_word(input logic [1:0] rate, input logic cp,
                                          input logic c0, input logic [7:0] cat);
    logic [15:0] w;
    w = 16'h0;
    for (int i = 0; i < 8; i++) w[5+i] = cat[i];
    w[4] = c0; w[3] = cp; w[2] = rate[1]; w[1] = rate[0];
    return w;
  endfunction

  function automatic logic route(input logic [5:0] lines, input logic [2:0] code);
    return (code > 3'd5) ? 1'b0 : lines[code];
  endfunction

  // A transfer of nbits serial clocks; returns the DO bits seen after the address,
  // plus the DO bits past the 16th data bit and the pending flag seen mid-frame.
  logic [15:0] rd_bits;
  logic        tail_or;
  logic        pend_mid;
  task automatic xfer(input logic [7:0] addr, input logic [15:0] data, input int nbits,
                      input int lock_at);
    rd_bits = '0; tail_or = 0; pend_mid = 0;
    sce = 1; tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i == lock_at) begin
        st_rate = 2'b11; st_category = 8'hFF; st_valid = 1; lock_lost = 1;
        tick(1); st_valid = 0; lock_lost = 0;
      end
      sclk = 0;
      sdi = (i < 8) ? addr[i] : ((i < 24) ? data[i-8] : 1'b1);
      tick(HALF);
      if (i >= 8 && i < 24) rd_bits[i-8] = sdo;
      if (i >= 24) tail_or = tail_or | sdo;
      if (i == 10) pend_mid = read_pending;
      sclk = 1; tick(HALF);
    end
    tick(HALF); sce = 0; tick(HALF); sclk = 0; tick(4);
  endtask

  task automatic set_status(input logic [1:0] r, input logic cp, input logic c0, input logic [7:0] cat);
    st_rate = r; st_copy_ok = cp; st_cs0 = c0; st_category = cat;
    st_valid = 1; tick(1); st_valid = 0; tick(1);
  endtask

  function automatic logic [15:0] wr_data(input logic [2:0] c);
    logic [15:0] d;
    d = 16'h0;
    d[4:0] = 5'h15 ^ {2'b0, c};
    d[15] = c[1];
    d[7:5] = c; d[10:8] = c + 3'd3; d[13:11] = c + 3'd5; d[14] = c[0];
    return d;
  endfunction

  task automatic chk_cfg(input logic [2:0] c, input string req);
    logic [9:0] act, exp;
    act = {fmt_lsb20, thru2_sel, thru1_sel, demod_sel};
    exp = {c[0], c + 3'd5, c + 3'd3, c};
    chk(act == exp, req, 32'(act), 32'(exp));
  endtask

  initial begin
    tick(3); rst_n = 1; tick(2);
    // R4 reset state
    chk({fmt_lsb20, thru2_sel, thru1_sel, demod_sel} == 10'h0, "R4 reset cfg",
        32'({fmt_lsb20, thru2_sel, thru1_sel, demod_sel}), 0);
    chk(sdo == 0 && read_pending == 0, "R10 R11 idle after reset", 32'({sdo, read_pending}), 0);
    din = 6'b101110; #1;
    chk(demod_in == 1'b0, "R5 reset routes line 0", 32'(demod_in), 0);

    // R8 R7 read after reset: cleared code D1=1 D2=0
    xfer(A_RD, 16'h0, 24, -1);
    chk(rd_bits == 16'h0002, "R8 cleared word after reset", 32'(rd_bits), 32'h0002);
    chk(pend_mid == 1'b1, "R11 pending during read", 32'(pend_mid), 1);
    chk(read_pending == 1'b0, "R11 pending drops after CE", 32'(read_pending), 0);

    // R2 R5 sweep all codes, all line patterns
    for (int c = 0; c < 8; c++) begin
      xfer(A_WR, wr_data(3'(c)), 24, -1);
      chk_cfg(3'(c), "R2 write fields");
      for (int p = 0; p < 64; p++) begin
        din = 6'(p); #1;
        chk({demod_in, thru1_out, thru2_out} ==
            {route(6'(p), 3'(c)), route(6'(p), 3'(c+3)), route(6'(p), 3'(c+5))},
            "R5 routing", 32'({demod_in, thru1_out, thru2_out}),
            32'({route(6'(p), 3'(c)), route(6'(p), 3'(c+3)), route(6'(p), 3'(c+5))}));
      end
    end
    // config now holds code 7; R1 wrong addresses ignored
    xfer(8'hA6, wr_data(3'd2), 24, -1);
    chk_cfg(3'd7, "R1 foreign address no write");
    chk(rd_bits == 16'h0 && pend_mid == 0, "R1 foreign address no read", 32'({pend_mid, rd_bits}), 0);
    xfer(8'h64, wr_data(3'd2), 24, -1);
    chk_cfg(3'd7, "R1 near-miss address no write");
    xfer(A_RD, wr_data(3'd2), 24, -1);
    chk_cfg(3'd7, "R1 read does not write");
    // R3 short and long frames
    xfer(A_WR, wr_data(3'd2), 23, -1);
    chk_cfg(3'd7, "R3 short write ignored");
    xfer(A_WR, wr_data(3'd2), 28, -1);
    chk_cfg(3'd2, "R3 long write commits");

    // R6 R7 R9 status sweep
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] cat;
        cat = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : (k == 2) ? 8'hA5 : 8'h3C;
        set_status(2'(r), k[0], k[1], cat);
        xfer(A_RD, 16'h0, 24, -1);
        chk(rd_bits == exp_word(2'(r), k[0], k[1], cat), "R6 R7 R9 read word",
            32'(rd_bits), 32'(exp_word(2'(r), k[0], k[1], cat)));
      end
    end

    // R8 lock loss clears; priority over valid
    set_status(2'b10, 1, 1, 8'h5A);
    lock_lost = 1; tick(1); lock_lost = 0; tick(1);
    xfer(A_RD, 16'h0, 24, -1);
    chk(rd_bits == 16'h0002, "R8 lock loss clears", 32'(rd_bits), 32'h0002);
    st_rate = 2'b11; st_category = 8'h77; st_valid = 1; lock_lost = 1; tick(1);
    st_valid = 0; lock_lost = 0; tick(1);
    xfer(A_RD, 16'h0, 24, -1);
    chk(rd_bits == 16'h0002, "R8 lock wins over valid", 32'(rd_bits), 32'h0002);

    // R10 snapshot stability and tail zeros
    set_status(2'b10, 1, 0, 8'hC3);
    xfer(A_RD, 16'h0, 28, 14);
    chk(rd_bits == exp_word(2'b10, 1, 0, 8'hC3), "R10 snapshot stable",
        32'(rd_bits), 32'(exp_word(2'b10, 1, 0, 8'hC3)));
    chk(tail_or == 1'b0, "R10 zero after 16 bits", 32'(tail_or), 0);
    xfer(A_RD, 16'h0, 24, -1);
    chk(rd_bits == 16'h0002, "R8 R10 next read sees clear", 32'(rd_bits), 32'h0002);
    chk_cfg(3'd2, "R4 cfg untouched by reads");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule